// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Unit

This unit merges the four interrupt causes of a UART into one interrupt line. It also provides an identification register that software reads to learn which cause to service first. Each cause has a sticky pending flag. The flag is set by a one-cycle event pulse from the block that owns the cause, and it is cleared only by the acknowledge that belongs to that cause. The four causes are: a receive error or break, receive data available, transmit holding register empty, and a change on the modem status lines. An enable register selects which pending causes may raise the interrupt and appear in the identification register.

Software reaches the two registers through a simple register bus: the enable register sits at address 1 and the identification register at address 2. The neighbouring blocks signal the acknowledge actions with strobes: the line status read, the receive data read, the modem status read and the transmit data write. Reading the identification register is itself the acknowledge for the transmit-empty cause, but only when that cause is the one being reported. The identification register also shows whether the FIFOs are enabled.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A bus write to address 1 stores write-data bits 3..0 as the enable mask: bit 0 receive data, bit 1 transmit empty, bit 2 line status error, bit 3 modem change. Read data at address 1 returns the mask in bits 3..0 and zero in bits 7..4. Read data at any address other than 1 and 2 is zero.
- R2: Identification bits 7..6 read 11 when `fifo_en` is high and 00 when it is low. Bits 5..4 always read 0.
- R3: Identification bit 0 reads 1 when no enabled cause is pending and 0 when at least one is.
- R4: Identification bits 3..1 hold the code of the highest-priority cause that is both enabled and pending. From highest to lowest: line status error 011, receive data 010, transmit empty 001, modem change 000. With nothing pending the register reads 0x01 (0xC1 with FIFOs enabled).
- R5: A cause's pending flag is set by its event pulse whether or not it is enabled. A pending but disabled cause shows up as soon as its enable bit is set.
- R6: A pending line status error clears only on `lsr_rd_ack`. The acknowledges of the other causes leave it set.
- R7: Pending receive data clears on `rbr_rd_ack`.
- R8: A pending modem change clears on `msr_rd_ack`.
- R9: Pending transmit empty clears on `thr_wr_ack`. It also clears on a read strobe (`reg_rd`) at address 2 while transmit empty is the reported code. A read strobe at address 2 while a higher cause is reported leaves it set.
- R10: `irq` is high exactly when at least one enabled cause is pending.
- R11: When an event pulse and its acknowledge arrive in the same cycle, the cause stays pending.
- R12: After reset the enable mask is 0, no cause is pending, `irq` is low and the identification register reads 0x01 (with `fifo_en` low).
- R13: Read data follows `reg_addr` combinationally. Events, acknowledges and writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (carries the read side effect) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| fifo_en | input | 1 | FIFOs enabled, shown in identification bits 7..6 |
| rx_data_evt | input | 1 | Pulse: receive data became available |
| thr_empty_evt | input | 1 | Pulse: transmit holding register became empty |
| line_err_evt | input | 1 | Pulse: receive error or break detected |
| modem_chg_evt | input | 1 | Pulse: modem status input changed |
| rbr_rd_ack | input | 1 | Strobe: software read the receive data register |
| thr_wr_ack | input | 1 | Strobe: software wrote the transmit data register |
| lsr_rd_ack | input | 1 | Strobe: software read the line status register |
| msr_rd_ack | input | 1 | Strobe: software read the modem status register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the conditional clear of transmit empty by an identification read. It needs a read while transmit empty is the top cause, and a second read while a higher cause masks it, with the transmit-empty flag staying set through the masked read. The stimulus table builds both situations by stacking events from lowest to highest priority and then removing the causes one acknowledge at a time. The table also covers a line error that is latched while disabled and then enabled, and an event that coincides with its own acknowledge.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants for the UART interrupt unit.
// Assumes four causes in a fixed order; the order is also the enable bit order.
package uart_irq_pkg;
    localparam int NUM_SRC  = 4;
    localparam int SRC_RX   = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_LSR  = 2;
    localparam int SRC_MSR  = 3;
    localparam int CODE_W   = 3;

    typedef logic [CODE_W-1:0] irq_code_t;

    localparam irq_code_t CODE_LSR  = 3'b011;
    localparam irq_code_t CODE_RX   = 3'b010;
    localparam irq_code_t CODE_THRE = 3'b001;
    localparam irq_code_t CODE_MSR  = 3'b000;
endpackage

// File: rtl/uart_irq_src.sv
// Module: sticky pending flag for one interrupt cause.
// Assumes set_i and clr_i are single-cycle strobes; set has priority over clear.
module uart_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Latch the event, drop it on acknowledge, keep it when both coincide.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (set_i)
            pend_o <= 1'b1;
        else if (clr_i)
            pend_o <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority encoder over the enabled pending causes.
// Assumes act_i is indexed by the package's SRC_* constants.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] act_i,
    output irq_code_t          code_o,
    output logic               none_o
);
    // Pick the highest-priority active cause; fall back to the lowest code.
    always_comb begin
        none_o = ~|act_i;
        if (act_i[SRC_LSR])
            code_o = CODE_LSR;
        else if (act_i[SRC_RX])
            code_o = CODE_RX;
        else if (act_i[SRC_THRE])
            code_o = CODE_THRE;
        else
            code_o = CODE_MSR;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: UART interrupt enable and identification unit (top).
// Holds the enable mask, one pending flag per cause, the priority encoder
// and the read mux for the two registers. Assumes a single-cycle bus:
// read data follows the address combinationally, and only a read strobe
// at the identification address has a side effect.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int IER_ADDR = 1,
    parameter int IIR_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              fifo_en,
    input  logic              rx_data_evt,
    input  logic              thr_empty_evt,
    input  logic              line_err_evt,
    input  logic              modem_chg_evt,
    input  logic              rbr_rd_ack,
    input  logic              thr_wr_ack,
    input  logic              lsr_rd_ack,
    input  logic              msr_rd_ack,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] IER_A = ADDR_W'(IER_ADDR);
    localparam logic [ADDR_W-1:0] IIR_A = ADDR_W'(IIR_ADDR);

    logic [NUM_SRC-1:0] ier_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;
    logic [NUM_SRC-1:0] act_v;
    irq_code_t          code;
    logic               none;
    logic               iir_thre_rd;
    logic [3:0]         unused_wdata_hi;

    assign unused_wdata_hi = reg_wdata[7:4];

    // Store the enable mask on a write to the enable address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ier_q <= '0;
        else if (reg_wr && reg_addr == IER_A)
            ier_q <= reg_wdata[NUM_SRC-1:0];
    end

    // An identification read acknowledges transmit empty only while it is reported.
    assign iir_thre_rd = reg_rd && (reg_addr == IIR_A) && !none && (code == CODE_THRE);

    // Route each cause's event and acknowledge to its flag.
    always_comb begin
        set_v           = '0;
        clr_v           = '0;
        set_v[SRC_RX]   = rx_data_evt;
        set_v[SRC_THRE] = thr_empty_evt;
        set_v[SRC_LSR]  = line_err_evt;
        set_v[SRC_MSR]  = modem_chg_evt;
        clr_v[SRC_RX]   = rbr_rd_ack;
        clr_v[SRC_THRE] = thr_wr_ack | iir_thre_rd;
        clr_v[SRC_LSR]  = lsr_rd_ack;
        clr_v[SRC_MSR]  = msr_rd_ack;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        uart_irq_src i_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend_q[g])
        );
    end

    assign act_v = pend_q & ier_q;

    uart_irq_prio i_prio (
        .act_i  (act_v),
        .code_o (code),
        .none_o (none)
    );

    assign irq = !none;

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == IER_A)
            reg_rdata = {{(8-NUM_SRC){1'b0}}, ier_q};
        else if (reg_addr == IIR_A)
            reg_rdata = {{2{fifo_en}}, 2'b00, code, none};
    end
endmodule

// File: rtl/uart_irq_chk.sv
// Module: property checker for uart_irq_ctrl, attached by bind.
// Assumes it sees the pending flags and enable mask of the top module.
module uart_irq_chk #(
    parameter int ADDR_W   = 3,
    parameter int IER_ADDR = 1,
    parameter int IIR_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              fifo_en,
    input logic              irq,
    input logic              rx_data_evt,
    input logic              line_err_evt,
    input logic              rbr_rd_ack,
    input logic              lsr_rd_ack,
    input logic [3:0]        pend,
    input logic [3:0]        ier
);
    localparam logic [ADDR_W-1:0] IER_A = ADDR_W'(IER_ADDR);
    localparam logic [ADDR_W-1:0] IIR_A = ADDR_W'(IIR_ADDR);

    assert_ier_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IER_A) |-> (reg_rdata[7:4] == 4'h0));

    assert_fifo_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IIR_A) |-> (reg_rdata[7:6] == {2{fifo_en}} && reg_rdata[5:4] == 2'b00));

    assert_nint_vs_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IIR_A) |-> (reg_rdata[0] == !irq));

    assert_lsr_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IIR_A && pend[2] && ier[2]) |-> (reg_rdata[3:1] == 3'b011));

    assert_lsr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[2] && !lsr_rd_ack) |=> pend[2]);

    assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && rbr_rd_ack && !rx_data_evt) |=> !pend[0]);

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & ier) != 4'h0));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_err_evt |=> pend[2]);
endmodule

bind uart_irq_ctrl uart_irq_chk #(
    .ADDR_W   (ADDR_W),
    .IER_ADDR (IER_ADDR),
    .IIR_ADDR (IIR_ADDR)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .fifo_en      (fifo_en),
    .irq          (irq),
    .rx_data_evt  (rx_data_evt),
    .line_err_evt (line_err_evt),
    .rbr_rd_ack   (rbr_rd_ack),
    .lsr_rd_ack   (lsr_rd_ack),
    .pend         (pend_q),
    .ier          (ier_q)
);

// File: tb/test_uart_irq_ctrl.sv
// Bench for uart_irq_ctrl: a vector table walked by one loop, then directed tests.
module test_uart_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fifo_en = 1'b0;
    logic       rx_data_evt = 1'b0, thr_empty_evt = 1'b0, line_err_evt = 1'b0, modem_chg_evt = 1'b0;
    logic       rbr_rd_ack = 1'b0, thr_wr_ack = 1'b0, lsr_rd_ack = 1'b0, msr_rd_ack = 1'b0;
    logic       irq;
    int         checks = 0;
    int         failures = 0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata, .fifo_en,
        .rx_data_evt, .thr_empty_evt, .line_err_evt, .modem_chg_evt,
        .rbr_rd_ack, .thr_wr_ack, .lsr_rd_ack, .msr_rd_ack, .irq
    );

    // Vector: {wr, ier[3:0], evt[3:0], ack[3:0], rd_iir, fifo, exp_iir[7:0], exp_irq}
    // evt/ack bit order: 0 rx / rbr read, 1 thre / thr write, 2 lsr, 3 msr.
    localparam int NV = 21;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 8'h01, 1'b0}, // enable all, idle
        {1'b0, 4'h0, 4'h8, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1}, // modem change: code 000
        {1'b0, 4'h0, 4'h2, 4'h0, 1'b0, 1'b0, 8'h02, 1'b1}, // thre over msr
        {1'b0, 4'h0, 4'h1, 4'h0, 1'b0, 1'b0, 8'h04, 1'b1}, // rx over thre
        {1'b0, 4'h0, 4'h4, 4'h0, 1'b0, 1'b0, 8'h06, 1'b1}, // lsr on top
        {1'b0, 4'h0, 4'h0, 4'h8, 1'b0, 1'b0, 8'h06, 1'b1}, // R8 msr clears, R6 lsr stays
        {1'b0, 4'h0, 4'h0, 4'h4, 1'b0, 1'b0, 8'h04, 1'b1}, // R6 lsr read clears
        {1'b0, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 8'h02, 1'b1}, // R7 rbr read clears
        {1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 8'h01, 1'b0}, // R9 iir read clears reported thre
        {1'b0, 4'h0, 4'h3, 4'h0, 1'b0, 1'b0, 8'h04, 1'b1}, // thre + rx together
        {1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 8'h04, 1'b1}, // R9 iir read with rx reported
        {1'b0, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 8'h02, 1'b1}, // R9 thre still pending
        {1'b0, 4'h0, 4'h0, 4'h2, 1'b0, 1'b0, 8'h01, 1'b0}, // R9 thr write clears
        {1'b1, 4'h0, 4'h4, 4'h0, 1'b0, 1'b0, 8'h01, 1'b0}, // R5 lsr latched while disabled
        {1'b1, 4'h4, 4'h0, 4'h0, 1'b0, 1'b0, 8'h06, 1'b1}, // R5 enabling exposes it
        {1'b0, 4'h0, 4'h4, 4'h4, 1'b0, 1'b0, 8'h06, 1'b1}, // R11 event wins over ack
        {1'b0, 4'h0, 4'h0, 4'h4, 1'b0, 1'b0, 8'h01, 1'b0}, // R6 cleared
        {1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 8'hC1, 1'b0}, // R2 fifo bits
        {1'b0, 4'h0, 4'h8, 4'h0, 1'b0, 1'b1, 8'hC1, 1'b0}, // R5 msr masked
        {1'b1, 4'h8, 4'h0, 4'h0, 1'b0, 1'b1, 8'hC0, 1'b1}, // R5 msr enabled
        {1'b0, 4'h0, 4'h0, 4'h8, 1'b0, 1'b1, 8'hC1, 1'b0}  // R8 msr read clears
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then peek the identification register.
    task automatic step(input logic [23:0] v);
        @(negedge clk);
        reg_wr        = v[23];
        reg_wdata     = {4'h0, v[22:19]};
        {modem_chg_evt, line_err_evt, thr_empty_evt, rx_data_evt} = v[18:15];
        {msr_rd_ack, lsr_rd_ack, thr_wr_ack, rbr_rd_ack} = v[14:11];
        reg_rd        = v[10];
        fifo_en       = v[9];
        reg_addr      = v[10] ? 3'd2 : (v[23] ? 3'd1 : 3'd0);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        {modem_chg_evt, line_err_evt, thr_empty_evt, rx_data_evt} = 4'h0;
        {msr_rd_ack, lsr_rd_ack, thr_wr_ack, rbr_rd_ack} = 4'h0;
        reg_addr = 3'd2;
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        reg_addr = 3'd1; #1;
        check8("R12 ier after reset", reg_rdata, 8'h00);
        reg_addr = 3'd2; #1;
        check8("R12 iir after reset", reg_rdata, 8'h01);
        check8("R12 irq after reset", {7'b0, irq}, 8'h00);

        // R3 R4 R10 via table
        for (int k = 0; k < NV; k++) begin
            step(VEC[k]);
            check8($sformatf("R3/R4 iir vector %0d", k), reg_rdata, VEC[k][8:1]);
            check8($sformatf("R10 irq vector %0d", k), {7'b0, irq}, {7'b0, VEC[k][0]});
        end

        // R1: upper write bits dropped, other addresses read zero
        step({1'b1, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0});
        @(negedge clk); reg_addr = 3'd1; reg_wr = 1'b1; reg_wdata = 8'hF5;
        @(negedge clk); reg_wr = 1'b0; #1;
        check8("R1 ier readback", reg_rdata, 8'h05);
        reg_addr = 3'd4; #1;
        check8("R1 other address", reg_rdata, 8'h00);

        // R13: read data follows address with no clock edge
        reg_addr = 3'd2; #1;
        check8("R13 combinational read", reg_rdata, 8'h01);

        // R12: reset mid-operation clears flags and mask
        step({1'b0, 4'h0, 4'h4, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0});
        check8("R12 lsr pending before reset", reg_rdata, 8'h06);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check8("R12 iir after mid reset", reg_rdata, 8'h01);
        reg_addr = 3'd1; #1;
        check8("R12 ier after mid reset", reg_rdata, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule